// File: doc/BRIEF.md
# PHY Management Bus Master

This block drives the two-wire station management bus that a MAC uses to configure and watch an Ethernet PHY. It produces the management clock (MDC) from the system clock, shifts out the serial management frame on the shared data line (MDIO), and captures the sixteen bits a PHY returns. The host supplies a clock divider, a PHY address, a register address and a write value, then pulses a command strobe that selects a write, a single read or a continuous scan.

A frame starts with thirty-two ones unless the host asks to suppress them. Then come the start pattern `01`, the opcode (`01` write, `10` read), the five-bit PHY address and the five-bit register address, all most significant bit first. A two-bit turnaround follows, then sixteen data bits. On a read the block releases MDIO from the turnaround onward and samples the line at each rising MDC edge. In scan mode it repeats read frames back to back with no gap. Each completed frame refreshes a link-fail flag and clears the "not yet valid" flag, so software can watch link state without issuing commands.

Top module: `mdio_master`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `stat_busy`, `stat_invalid`, `stat_link_fail`, `mdc` and `mdio_oe` are 0 and `rd_data` is 0.
- R2: The MDC period is P system cycles, where P is `cfg_div` with bit 0 forced to 0, or 2 if that value is below 2. MDC is high for P/2 cycles of each bit and is low whenever the block is idle.
- R3: A write (`cmd_bits[2]`) sends ones ×32, `01`, `01`, PHY address, register address, turnaround `10` and `cfg_wdata`, all MSB first, with MDIO driven for the whole frame.
- R4: A read (`cmd_bits[1]`) sends opcode `10` and releases MDIO (`mdio_oe`=0) from the turnaround to the end of the frame. It samples `mdio_i` on each MDC rising edge and presents the sixteen data bits on `rd_data` when the frame ends. An absent PHY leaves the line pulled high, which reads as 16'hFFFF.
- R5: With `cfg_nopre`=1 the 32-bit preamble is omitted, so a frame lasts 32·P cycles instead of 64·P.
- R6: `stat_busy` rises on the clock edge that accepts a command and stays high for exactly (frame bits)·P cycles for a write or read.
- R7: A command strobe that arrives while `stat_busy` is high has no effect, except the scan stop described in R11.
- R8: When several command bits are set, write takes priority over read, and read over scan.
- R9: Divider, preamble mode, addresses and write data are captured at acceptance. Changing them during a frame has no effect on that frame.
- R10: A scan (`cmd_bits[0]`) sets `stat_invalid`, then runs read frames back to back. After each frame it loads `rd_data` and sets `stat_link_fail` to the inverse of bit 2 of the returned word. `stat_invalid` clears when the first frame completes.
- R11: A strobe with `cmd_bits`=0 during a scan ends the scan once the current frame completes. MDC then stays low and `stat_busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command strobe, one cycle |
| cmd_bits | input | 3 | bit0 scan, bit1 read, bit2 write |
| cfg_div | input | DIV_W | MDC divider (bit 0 ignored) |
| cfg_nopre | input | 1 | Suppress the 32-bit preamble |
| cfg_phy | input | 5 | PHY address |
| cfg_reg | input | 5 | Register address |
| cfg_wdata | input | 16 | Write data |
| rd_data | output | 16 | Last word read |
| stat_link_fail | output | 1 | Link down, from scan |
| stat_busy | output | 1 | Frame in progress |
| stat_invalid | output | 1 | Scan started, no data yet |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data out |
| mdio_oe | output | 1 | Data output enable |
| mdio_i | input | 1 | Data in |

## Verification
Every result is due on a cycle fixed by P and the frame length. `stat_busy` stays high for exactly 64·P or 32·P cycles after the accepting edge. `rd_data` and the scan flags change on the same edge that ends the frame. The bench counts busy cycles at falling clock edges and compares the count with that product. It reads `rd_data` only after busy has dropped, and times the clearing of `stat_invalid` to the same 64·P count. An MDC-driven PHY model in the bench decodes frames and drives read data on falling MDC edges, so that read data is stable at the master's sampling edge. The model also counts any cycle where both sides drive the line.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;

    localparam int PRE_LEN    = 32;
    localparam int FRAME_LEN  = 64;
    localparam int REL_START  = 46;   // first bit index released on reads (turnaround)
    localparam int DATA_START = 48;   // first data bit index
    localparam int DW         = 16;
    localparam int AW         = 5;
    localparam int IW         = $clog2(FRAME_LEN);

    typedef enum logic [1:0] {
        XF_SCAN  = 2'd0,
        XF_READ  = 2'd1,
        XF_WRITE = 2'd2
    } xfer_e;

    typedef struct packed {
        xfer_e           kind;
        logic            nopre;
        logic [AW-1:0]   phy;
        logic [AW-1:0]   regad;
        logic [DW-1:0]   wdata;
    } job_t;

    // write beats read beats scan
    function automatic xfer_e decode_cmd(input logic [2:0] c);
        if (c[2])      return XF_WRITE;
        else if (c[1]) return XF_READ;
        else           return XF_SCAN;
    endfunction

    function automatic logic [FRAME_LEN-1:0] frame_bits(input job_t j);
        logic wr;
        wr = (j.kind == XF_WRITE);
        return {{PRE_LEN{1'b1}}, 2'b01, (wr ? 2'b01 : 2'b10), j.phy, j.regad,
                (wr ? 2'b10 : 2'b11), (wr ? j.wdata : {DW{1'b1}})};
    endfunction

    function automatic logic host_drives(input xfer_e k, input logic [IW-1:0] idx);
        return (k == XF_WRITE) || (idx < IW'(REL_START));
    endfunction

endpackage

// File: rtl/mdc_timer.sv
`timescale 1ns/1ps
module mdc_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             at_rise,
    output logic             at_end
);
    logic [DIV_W-1:0] period;
    logic [DIV_W-1:0] half;
    logic [DIV_W-1:0] ph;

    always_comb begin
        period = {div[DIV_W-1:1], 1'b0};
        if (div[DIV_W-1:1] == '0) period = DIV_W'(2);
        half = period >> 1;
    end

    assign at_rise = run && (ph == half - 1'b1);
    assign at_end  = run && (ph == period - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ph  <= '0;
            mdc <= 1'b0;
        end else if (at_end) begin
            ph  <= '0;
            mdc <= 1'b0;
        end else begin
            ph <= ph + 1'b1;
            if (at_rise) mdc <= 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame.sv
`timescale 1ns/1ps
module mdio_frame
    import mdio_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          again,
    input  job_t          job_in,
    input  logic          at_rise,
    input  logic          at_end,
    input  logic          mdio_i,
    output logic          mdio_o,
    output logic          mdio_oe,
    output logic          done,
    output logic [DW-1:0] rd_word
);
    job_t                 job_q;
    logic [IW-1:0]        idx;
    logic [FRAME_LEN-1:0] fr_new;
    logic [FRAME_LEN-1:0] fr_cur;
    logic [IW-1:0]        first_new;
    logic [IW-1:0]        first_cur;
    logic [IW-1:0]        nxt;
    logic                 last;

    assign fr_new    = frame_bits(job_in);
    assign fr_cur    = frame_bits(job_q);
    assign first_new = job_in.nopre ? IW'(PRE_LEN) : '0;
    assign first_cur = job_q.nopre  ? IW'(PRE_LEN) : '0;
    assign last      = (idx == IW'(FRAME_LEN - 1));
    assign done      = at_end && last;
    assign nxt       = last ? first_cur : idx + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            job_q   <= '0;
            idx     <= '0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
            rd_word <= '0;
        end else begin
            if (start) begin
                job_q   <= job_in;
                idx     <= first_new;
                mdio_o  <= fr_new[IW'(FRAME_LEN - 1) - first_new];
                mdio_oe <= host_drives(job_in.kind, first_new);
            end else if (at_end) begin
                if (last && !again) begin
                    mdio_o  <= 1'b1;
                    mdio_oe <= 1'b0;
                end else begin
                    idx     <= nxt;
                    mdio_o  <= fr_cur[IW'(FRAME_LEN - 1) - nxt];
                    mdio_oe <= host_drives(job_q.kind, nxt);
                end
            end
            if (at_rise && (idx >= IW'(DATA_START)))
                rd_word <= {rd_word[DW-2:0], mdio_i};
        end
    end
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_wr,
    input  logic [2:0]       cmd_bits,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_nopre,
    input  logic [4:0]       cfg_phy,
    input  logic [4:0]       cfg_reg,
    input  logic [15:0]      cfg_wdata,
    output logic [15:0]      rd_data,
    output logic             stat_link_fail,
    output logic             stat_busy,
    output logic             stat_invalid,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    localparam int LINK_BIT = 2;

    job_t             job_in;
    xfer_e            kind_q;
    logic [DIV_W-1:0] div_q;
    logic             scan_on;
    logic             stop_req;
    logic             accept;
    logic             stop_set;
    logic             again;
    logic             at_rise;
    logic             at_end;
    logic             done;
    logic [DW-1:0]    word;

    assign accept   = cmd_wr && !stat_busy && (cmd_bits != 3'b000);
    assign stop_set = cmd_wr && stat_busy && scan_on && (cmd_bits == 3'b000);
    assign again    = scan_on && !stop_req;

    always_comb begin
        job_in.kind  = decode_cmd(cmd_bits);
        job_in.nopre = cfg_nopre;
        job_in.phy   = cfg_phy;
        job_in.regad = cfg_reg;
        job_in.wdata = cfg_wdata;
    end

    mdc_timer #(.DIV_W(DIV_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (stat_busy),
        .div     (div_q),
        .mdc     (mdc),
        .at_rise (at_rise),
        .at_end  (at_end)
    );

    mdio_frame u_frame (
        .clk     (clk),
        .rst     (rst),
        .start   (accept),
        .again   (again),
        .job_in  (job_in),
        .at_rise (at_rise),
        .at_end  (at_end),
        .mdio_i  (mdio_i),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .done    (done),
        .rd_word (word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q         <= XF_SCAN;
            div_q          <= '0;
            scan_on        <= 1'b0;
            stop_req       <= 1'b0;
            stat_busy      <= 1'b0;
            stat_invalid   <= 1'b0;
            stat_link_fail <= 1'b0;
            rd_data        <= '0;
        end else if (accept) begin
            kind_q    <= job_in.kind;
            div_q     <= cfg_div;
            stat_busy <= 1'b1;
            scan_on   <= (job_in.kind == XF_SCAN);
            stop_req  <= 1'b0;
            if (job_in.kind == XF_SCAN) stat_invalid <= 1'b1;
        end else begin
            if (stop_set) stop_req <= 1'b1;
            if (done) begin
                if (kind_q != XF_WRITE) rd_data <= word;
                if (kind_q == XF_SCAN) begin
                    stat_link_fail <= ~word[LINK_BIT];
                    stat_invalid   <= 1'b0;
                end
                if (!again) begin
                    stat_busy <= 1'b0;
                    scan_on   <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/mdio_master_chk.sv
`timescale 1ns/1ps
module mdio_master_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_wr,
    input logic [2:0] cmd_bits,
    input logic       mdc,
    input logic       mdio_oe,
    input logic       stat_busy,
    input logic       stat_invalid
);
    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        rst |=> (!stat_busy && !mdio_oe && !mdc && !stat_invalid));

    // R6
    oe_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        mdio_oe |-> stat_busy);

    // R2
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        mdc |-> stat_busy);

    // R7
    busy_from_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_busy) |-> $past(cmd_wr));

    // R10
    invalid_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(stat_invalid) |-> $past(stat_busy));

    // R10
    invalid_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_invalid) |-> $past(cmd_wr && cmd_bits == 3'b001));
endmodule

bind mdio_master mdio_master_chk u_chk (.*);

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
    localparam logic [4:0] PHYAD = 5'd3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_wr = 1'b0;
    logic [2:0]  cmd_bits = 3'b000;
    logic [7:0]  cfg_div = 8'd4;
    logic        cfg_nopre = 1'b0;
    logic [4:0]  cfg_phy = 5'd0;
    logic [4:0]  cfg_reg = 5'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic [15:0] rd_data;
    logic        stat_link_fail, stat_busy, stat_invalid;
    logic        mdc, dut_o, dut_oe;
    logic        line;

    logic        resp_oe = 1'b0;
    logic        resp_bit = 1'b1;

    assign line = resp_oe ? resp_bit : (dut_oe ? dut_o : 1'b1);

    always #2.5 clk = ~clk;

    mdio_master #(.DIV_W(8)) u_dut (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_bits(cmd_bits),
        .cfg_div(cfg_div), .cfg_nopre(cfg_nopre), .cfg_phy(cfg_phy),
        .cfg_reg(cfg_reg), .cfg_wdata(cfg_wdata), .rd_data(rd_data),
        .stat_link_fail(stat_link_fail), .stat_busy(stat_busy),
        .stat_invalid(stat_invalid), .mdc(mdc), .mdio_o(dut_o),
        .mdio_oe(dut_oe), .mdio_i(line)
    );

    // ---------------- PHY model ----------------
    logic [15:0] mem [32];
    logic [15:0] exp_mem [32];
    int          rstate = 0, hcnt = 0, wcnt = 0, rcnt = 0, contention = 0;
    logic [13:0] hdr;
    logic [17:0] wsh;
    logic [15:0] rword;
    logic        rmatch = 1'b0;
    logic [4:0]  rreg;
    logic [1:0]  last_ta = 2'b00;

    always @(posedge mdc) begin
        if (dut_oe && resp_oe) contention++;
        case (rstate)
            0: if (dut_oe && !line) begin hdr = 14'd0; hcnt = 1; rstate = 1; end
            1: begin
                hdr = {hdr[12:0], line};
                hcnt++;
                if (hcnt == 14) begin
                    rmatch = (hdr[9:5] == PHYAD);
                    rreg   = hdr[4:0];
                    if (hdr[12] && hdr[11:10] == 2'b01) begin wcnt = 0; rstate = 3; end
                    else if (hdr[12] && hdr[11:10] == 2'b10) begin rword = mem[rreg]; rcnt = 0; rstate = 2; end
                    else rstate = 0;
                end
            end
            3: begin
                wsh = {wsh[16:0], line};
                wcnt++;
                if (wcnt == 18) begin
                    if (rmatch) mem[rreg] = wsh[15:0];
                    last_ta = wsh[17:16];
                    rstate = 0;
                end
            end
            default: ;
        endcase
    end

    always @(negedge mdc) begin
        if (rstate == 2) begin
            if (rcnt == 1) begin resp_oe = rmatch; resp_bit = 1'b0; end
            else if (rcnt >= 2 && rcnt <= 17) resp_bit = rword[17 - rcnt];
            else if (rcnt == 18) begin resp_oe = 1'b0; rstate = 0; end
            rcnt++;
        end
    end

    // ---------------- bookkeeping ----------------
    int n_cmp = 0, n_bad = 0;

    function automatic int per(input int dv);
        int p;
        p = dv & ~1;
        return (p < 2) ? 2 : p;
    endfunction

    function automatic int flen(input bit np);
        return np ? 32 : 64;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic issue(input logic [2:0] c, input int dv, input bit np,
                         input logic [4:0] ph, input logic [4:0] rg, input logic [15:0] wd);
        @(negedge clk);
        cmd_bits = c; cfg_div = 8'(dv); cfg_nopre = np;
        cfg_phy = ph; cfg_reg = rg; cfg_wdata = wd; cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic wait_idle(output int cyc, output int hi);
        int hcur;
        cyc = 0; hi = 0; hcur = 0;
        while (stat_busy) begin
            cyc++;
            if (mdc) hcur++;
            else if (hcur != 0) begin hi = hcur; hcur = 0; end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int cyc, hi, c, seen;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) begin
            mem[i] = 16'(i * 16'h1357) ^ 16'h2C4A;
            exp_mem[i] = mem[i];
        end
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(!stat_busy && !stat_invalid && !stat_link_fail, "R1 status", {stat_busy, stat_invalid, stat_link_fail}, 0);
        chk(!mdc && !dut_oe && rd_data == 16'd0, "R1 bus", {mdc, dut_oe, rd_data}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!stat_busy && !mdc, "R1 after release", {stat_busy, mdc}, 0);

        // R3 directed write, R6 duration, R2 high phase
        issue(3'b100, 6, 0, PHYAD, 5'd5, 16'hBEEF);
        wait_idle(cyc, hi);
        exp_mem[5] = 16'hBEEF;
        chk(cyc == 64 * 6, "R6 write busy", cyc, 64 * 6);
        chk(hi == 3, "R2 high half", hi, 3);
        chk(mem[5] == 16'hBEEF, "R3 write data", mem[5], 16'hBEEF);
        chk(last_ta == 2'b10, "R3 turnaround", last_ta, 2);

        // R4 read back
        issue(3'b010, 6, 0, PHYAD, 5'd5, 16'h0);
        wait_idle(cyc, hi);
        chk(rd_data == 16'hBEEF, "R4 read data", rd_data, 16'hBEEF);
        chk(cyc == 64 * 6, "R6 read busy", cyc, 64 * 6);

        // R2 odd divider rounds down
        issue(3'b010, 7, 0, PHYAD, 5'd9, 16'h0);
        wait_idle(cyc, hi);
        chk(cyc == 64 * 6 && hi == 3, "R2 odd divider", cyc, 64 * 6);
        chk(rd_data == exp_mem[9], "R4 read reg9", rd_data, exp_mem[9]);

        // R2 divider floor
        issue(3'b010, 1, 0, PHYAD, 5'd2, 16'h0);
        wait_idle(cyc, hi);
        chk(cyc == 128 && hi == 1, "R2 div 1", cyc, 128);
        issue(3'b010, 0, 0, PHYAD, 5'd2, 16'h0);
        wait_idle(cyc, hi);
        chk(cyc == 128 && hi == 1, "R2 div 0", cyc, 128);

        // R5 no preamble
        issue(3'b100, 4, 1, PHYAD, 5'd20, 16'h0F1E);
        wait_idle(cyc, hi);
        exp_mem[20] = 16'h0F1E;
        chk(cyc == 32 * 4, "R5 nopre write busy", cyc, 128);
        chk(mem[20] == 16'h0F1E, "R5 nopre write data", mem[20], 16'h0F1E);
        issue(3'b010, 4, 1, PHYAD, 5'd20, 16'h0);
        wait_idle(cyc, hi);
        chk(cyc == 32 * 4 && rd_data == 16'h0F1E, "R5 nopre read", rd_data, 16'h0F1E);

        // R4 absent PHY reads ones
        issue(3'b010, 2, 0, 5'd17, 5'd5, 16'h0);
        wait_idle(cyc, hi);
        chk(rd_data == 16'hFFFF, "R4 absent phy", rd_data, 16'hFFFF);

        // R7 command during busy ignored
        issue(3'b010, 4, 0, PHYAD, 5'd7, 16'h0);
        repeat (20) @(negedge clk);
        issue(3'b100, 2, 1, PHYAD, 5'd7, 16'h1234);
        wait_idle(cyc, hi);
        chk(cyc == 64 * 4 - 22, "R7 busy length", cyc, 64 * 4 - 22);
        chk(mem[7] == exp_mem[7] && rd_data == exp_mem[7], "R7 no write", mem[7], exp_mem[7]);

        // R9 config latched
        issue(3'b100, 4, 0, PHYAD, 5'd12, 16'hA0A0);
        repeat (10) @(negedge clk);
        cfg_wdata = 16'h5555; cfg_reg = 5'd13; cfg_div = 8'd2; cfg_nopre = 1'b1;
        wait_idle(cyc, hi);
        exp_mem[12] = 16'hA0A0;
        chk(mem[12] == 16'hA0A0 && mem[13] == exp_mem[13], "R9 latched fields", mem[12], 16'hA0A0);
        chk(cyc == 64 * 4 - 10, "R9 latched divider", cyc, 64 * 4 - 10);

        // R8 priority
        issue(3'b111, 2, 0, PHYAD, 5'd14, 16'h5A5A);
        wait_idle(cyc, hi);
        exp_mem[14] = 16'h5A5A;
        chk(mem[14] == 16'h5A5A && cyc == 128 && !stat_invalid, "R8 write wins", mem[14], 16'h5A5A);
        issue(3'b011, 2, 0, PHYAD, 5'd12, 16'h0);
        wait_idle(cyc, hi);
        chk(rd_data == 16'hA0A0 && cyc == 128 && !stat_invalid, "R8 read over scan", rd_data, 16'hA0A0);

        // random mix (R3 R4 R6)
        for (int k = 0; k < 24; k++) begin
            bit       wr, np;
            int       dv;
            logic [4:0]  ph, rg;
            logic [15:0] wd, ex;
            wr = 1'($urandom_range(0, 1));
            np = 1'($urandom_range(0, 1));
            dv = $urandom_range(0, 9);
            ph = ($urandom_range(0, 3) == 0) ? 5'd9 : PHYAD;
            rg = 5'($urandom_range(0, 31));
            wd = 16'($urandom);
            issue(wr ? 3'b100 : 3'b010, dv, np, ph, rg, wd);
            wait_idle(cyc, hi);
            chk(cyc == flen(np) * per(dv) && hi == per(dv) / 2, "R6 random timing", cyc, flen(np) * per(dv));
            if (wr) begin
                if (ph == PHYAD) exp_mem[rg] = wd;
                chk(mem[rg] == exp_mem[rg], "R3 random write", mem[rg], exp_mem[rg]);
            end else begin
                ex = (ph == PHYAD) ? exp_mem[rg] : 16'hFFFF;
                chk(rd_data == ex, "R4 random read", rd_data, ex);
            end
        end

        // R10 scan
        mem[1] = 16'h796D; exp_mem[1] = 16'h796D;
        issue(3'b001, 2, 0, PHYAD, 5'd1, 16'h0);
        chk(stat_invalid && stat_busy, "R10 invalid set", {stat_invalid, stat_busy}, 3);
        c = 0;
        while (stat_invalid) begin c++; @(negedge clk); end
        chk(c == 128, "R10 invalid clear time", c, 128);
        chk(stat_busy && !stat_link_fail && rd_data == 16'h796D, "R10 first scan", rd_data, 16'h796D);
        mem[1] = 16'h7969; exp_mem[1] = 16'h7969;
        repeat (3 * 128) @(negedge clk);
        chk(stat_busy && stat_link_fail && rd_data == 16'h7969, "R10 link fail", {stat_busy, stat_link_fail}, 3);
        mem[1] = 16'h796D; exp_mem[1] = 16'h796D;
        repeat (3 * 128) @(negedge clk);
        chk(!stat_link_fail, "R10 link restored", stat_link_fail, 0);

        // R11 stop scan
        issue(3'b000, 2, 0, PHYAD, 5'd1, 16'h0);
        wait_idle(cyc, hi);
        chk(cyc <= 128, "R11 stop latency", cyc, 128);
        seen = 0;
        repeat (300) begin
            @(negedge clk);
            if (mdc || stat_busy || dut_oe) seen++;
        end
        chk(seen == 0 && !stat_invalid, "R11 quiet after stop", seen, 0);

        chk(contention == 0, "R4 line release", contention, 0);
        summary();
        $finish;
    end
endmodule